// File: doc/BRIEF.md
# Edge-to-Pulse Isolation Channel Encoder

This block is the transmit half of a pulse-coded isolation channel. It samples one logic input with the system clock and emits one-clock pulses on two outputs that stand for the two pulse polarities of a transformer link. A rising input edge produces a `set` pulse and a falling edge produces a `clr` pulse. A receiver holds a bistable latch that these pulses flip.

A static input would leave the receiver with no traffic at all. The encoder therefore repeats the current level after a programmable idle interval, and keeps repeating it at that interval while the input stays unchanged. The receiver uses these refresh pulses to recover the DC level, and it treats their absence as a dead transmitter.

A power-good input silences both outputs while the transmit side is unpowered. When power returns, the encoder sends one refresh pulse at once so that the receiver picks up the current level. The analog pulse shaping, the coupling and the supply sensing sit outside this block.

Top module: `eptx_encoder`

## Requirements
- R1: A rising edge on `data_i` produces exactly one cycle of `set_o` high. It appears in the third clock cycle after the edge is first sampled (two synchronizer flops, then the output flop).
- R2: A falling edge on `data_i` produces exactly one cycle of `clr_o` high, with the same latency as R1.
- R3: `set_o` and `clr_o` are never high in the same cycle.
- R4: While the input is static and power is good, a refresh pulse follows every IDLE_CYC cycles after the previous pulse. The refresh is `set_o` when the synchronized level is 1 and `clr_o` when it is 0. No pulse appears in between.
- R5: Every transition pulse restarts the idle interval, so the first refresh comes exactly IDLE_CYC cycles after the transition pulse.
- R6: When a transition pulse falls in the same cycle that a refresh is due, only the transition pulse is emitted, and the next refresh follows IDLE_CYC cycles later.
- R7: An input high for a single clock sample produces a `set_o` pulse followed on the next cycle by a `clr_o` pulse.
- R8: From the cycle after `pwr_ok_i` is sampled low, both outputs stay 0. Input edges that happen while power is low produce no transition pulse.
- R9: In the cycle after `pwr_ok_i` is first sampled high, one refresh pulse encodes the current level. This also applies at the first clock after reset. The next refresh follows IDLE_CYC cycles later.
- R10: While `rst_ni` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 1 | Asynchronous logic input to be encoded |
| pwr_ok_i | input | 1 | Transmit-side power good, synchronous to clk_i |
| set_o | output | 1 | One-cycle pulse: rising edge or refresh of level 1 |
| clr_o | output | 1 | One-cycle pulse: falling edge or refresh of level 0 |

## Verification
An input change made just after clock edge e reaches the outputs in the cycle that follows edge e+3. Power-good acts one edge later, at e+1. Each refresh lands an exact multiple of IDLE_CYC cycles after the pulse that started its interval. The bench logs both outputs in every cycle, indexed by edge count. After each stimulus it compares a whole window cycle by cycle against pulse positions it computes from these offsets. The gap between a rising and a falling input is swept from one cycle to past two idle intervals. This covers the single-sample pulse, the collision with a due refresh and several refreshes inside one level.

// File: rtl/eptx_pkg.sv
package eptx_pkg;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_SET  = 2'd1,
    PK_CLR  = 2'd2
  } pulse_e;

  function automatic pulse_e level_pulse(input logic level);
    return level ? PK_SET : PK_CLR;
  endfunction

endpackage

// File: rtl/eptx_sync.sv
module eptx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/eptx_edge.sv
module eptx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  // tracks even with power down, so edges seen while off are swallowed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;

endmodule

// File: rtl/eptx_idle_timer.sv
module eptx_idle_timer #(
  parameter int IDLE_CYC = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  output logic due_o
);

  localparam int CNT_W = (IDLE_CYC > 2) ? $clog2(IDLE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || restart_i) cnt_q <= '0;
    else if (cnt_q != LAST)      cnt_q <= cnt_q + 1'b1;
  end

  assign due_o = en_i && (cnt_q == LAST);

  AST_DUE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && en_i) |=> !due_o); // R5

endmodule

// File: rtl/eptx_encoder.sv
module eptx_encoder
  import eptx_pkg::*;
#(
  parameter int IDLE_CYC    = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic pwr_ok_i,
  output logic set_o,
  output logic clr_o
);

  logic   level;
  logic   rise, fall;
  logic   due;
  logic   pwr_q;
  logic   pwr_rise;
  pulse_e kind;
  logic   set_q, clr_q;

  eptx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (data_i),
    .q_o    (level)
  );

  eptx_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  eptx_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (pwr_ok_i),
    .restart_i (kind != PK_NONE),
    .due_o     (due)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwr_q <= 1'b0;
    else         pwr_q <= pwr_ok_i;
  end

  assign pwr_rise = pwr_ok_i & ~pwr_q;

  // transition beats refresh; wake-up refresh shares the refresh path
  always_comb begin
    kind = PK_NONE;
    if (pwr_ok_i) begin
      if (rise)                 kind = PK_SET;
      else if (fall)            kind = PK_CLR;
      else if (pwr_rise || due) kind = level_pulse(level);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      set_q <= (kind == PK_SET);
      clr_q <= (kind == PK_CLR);
    end
  end

  assign set_o = set_q;
  assign clr_o = clr_q;

  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_o && clr_o)); // R3
  AST_SET_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |=> !set_o); // R1
  AST_CLR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o); // R2
  AST_PWR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !(set_o || clr_o)); // R8
  AST_PWR_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_ok_i) |=> (set_o || clr_o)); // R9

endmodule

// File: tb/eptx_encoder_bench.sv
module eptx_encoder_bench;

  localparam int IDLE = 8;
  localparam int MAXC = 8192;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic data = 1'b0;
  logic pwr = 1'b1;
  logic set_w, clr_w;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int both_cnt = 0;
  logic [1:0] obs [MAXC];

  eptx_encoder #(.IDLE_CYC(IDLE)) u_eptx_encoder (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .data_i   (data),
    .pwr_ok_i (pwr),
    .set_o    (set_w),
    .clr_o    (clr_w)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cyc < MAXC) obs[cyc] = {set_w, clr_w};
    if (set_w && clr_w) both_cnt++;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check_at(input int idx, input logic es, input logic ec, input string req);
    checks++;
    if (obs[idx] !== {es, ec}) begin
      errors++;
      $display("FAIL %s cycle %0d actual set=%0b clr=%0b expected set=%0b clr=%0b",
               req, idx, obs[idx][1], obs[idx][0], es, ec);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int q0, e0, e1, f, r, d;
    string tag;

    // R10: reset holds outputs low
    wait_cyc(3);
    checks++;
    if (set_w !== 1'b0 || clr_w !== 1'b0) begin
      errors++;
      $display("FAIL R10 actual set=%0b clr=%0b expected set=0 clr=0", set_w, clr_w);
    end

    // R9: power already good at reset release -> immediate refresh of level 0
    rst_ni = 1'b1;
    q0 = cyc;
    wait_cyc(2 * IDLE + 3);
    for (int t = q0 + 1; t <= q0 + 1 + 2 * IDLE; t++) begin
      d = t - (q0 + 1);
      check_at(t, 1'b0, (d % IDLE) == 0, (d == 0) ? "R9" : "R4");
    end

    // gap sweep between rising and falling input
    for (int g = 1; g <= 2 * IDLE + 2; g++) begin
      data = 1'b1;
      e0 = cyc;
      wait_cyc(g);
      data = 1'b0;
      e1 = cyc;
      wait_cyc(2 * IDLE + 4);
      for (int t = e0 + 3; t <= e1 + 3 + 2 * IDLE; t++) begin
        if (t < e1 + 3) begin
          d = t - (e0 + 3);
          tag = (d == 0) ? "R1" : "R4";
          check_at(t, (d % IDLE) == 0, 1'b0, tag);
        end else begin
          d = t - (e1 + 3);
          if (d == 0) tag = (g == 1) ? "R7" : ((g == IDLE) ? "R6" : "R2");
          else        tag = "R5";
          check_at(t, 1'b0, (d % IDLE) == 0, tag);
        end
      end
    end

    // R8 / R9: power drop swallows edges, wake-up refresh encodes level
    for (int lv = 0; lv < 2; lv++) begin
      data = 1'b1;
      wait_cyc(5);
      f = cyc;
      pwr = 1'b0;
      wait_cyc(2);
      data = 1'b0;
      wait_cyc(3);
      data = 1'b1;
      wait_cyc(3);
      data = 1'b0;
      wait_cyc(3);
      data = lv[0];
      wait_cyc(3 * IDLE);
      r = cyc;
      pwr = 1'b1;
      wait_cyc(2 * IDLE + 3);
      for (int t = f + 1; t <= r; t++) check_at(t, 1'b0, 1'b0, "R8");
      for (int t = r + 1; t <= r + 1 + 2 * IDLE; t++) begin
        d = t - (r + 1);
        check_at(t, lv[0] && (d % IDLE) == 0, !lv[0] && (d % IDLE) == 0,
                 (d == 0) ? "R9" : "R4");
      end
    end

    // R3: never both outputs together over the whole run
    checks++;
    if (both_cnt != 0) begin
      errors++;
      $display("FAIL R3 actual overlap_cycles=%0d expected 0", both_cnt);
    end

    finish_run();
  end

endmodule